// File: doc/BRIEF.md
# Bank Auto-Precharge Tracker

This block watches the command stream that a DDR SDRAM controller issues and keeps a live picture of every bank. The picture has three parts: whether a row is open, whether the bank is precharging, and how far the bank has got through its row-active and precharge windows. Each command carries a bank address and an auto-precharge flag. The flag applies to that one read or write only.

When a burst asks for auto-precharge, the tracker starts the implicit precharge in the earliest cycle that an explicit precharge would have been legal. That cycle is the end of the burst, pushed back if needed until the minimum row-active time has elapsed. A burst-terminate command truncates the most recent plain read and leaves its row open. Any command that reaches a bank too early, or that does not suit the bank's state, is refused. The bank's state stays as it was, and a one-cycle error pulse follows.

The controller uses the per-bank open, precharging and idle flags to schedule its next commands. It uses the error pulse to catch protocol faults.

Top module: `bank_apc_tracker`

## Requirements
- R1: After reset every bank reports idle (not open, not precharging) and the error output is low.
- R2: ACTIVE (code 1) to an idle bank makes it report open from the next cycle. ACTIVE to a bank that is open or precharging raises the error output in the next cycle and changes nothing.
- R3: PRECHARGE (code 4) to an open bank fewer than T_RAS cycles after its ACTIVE raises the error and leaves the row open. Issued T_RAS or more cycles after the ACTIVE, it makes the bank report precharging from the next cycle and idle T_RP cycles after the command. PRECHARGE to an idle bank is accepted and changes nothing.
- R4: Any ACTIVE, READ, WRITE or PRECHARGE to a bank that is still precharging raises the error in the next cycle and is ignored.
- R5: READ (code 2) or WRITE (code 3) to a bank with no open row raises the error in the next cycle.
- R6: For a READ or WRITE issued at cycle r with auto-precharge set, to a bank activated at cycle a, the implicit precharge starts at cycle s = max(r + BURST_LEN/2, a + T_RAS). The bank reports open through cycle s, precharging from s+1, and idle from s + T_RP.
- R7: Auto-precharge is per command. A READ or WRITE without the flag leaves the row open indefinitely, even after an earlier auto-precharge to the same bank.
- R8: While an auto-precharge is pending on a bank, every command to that bank raises the error. Legal commands to other banks in that time raise no error.
- R9: BURST TERMINATE (code 5) during the burst of the most recent READ, when that READ had no auto-precharge, is accepted, ends the burst and leaves the row open. BURST TERMINATE at any other time raises the error, including a second one after a truncation, and when the latest burst was a WRITE or carried auto-precharge.
- R10: NOP (code 0) and the unused codes 6 and 7 change no bank state and never raise the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST TERMINATE |
| bank_i | input | BA_W | Bank addressed by the command |
| ap_i | input | 1 | Auto-precharge flag for READ/WRITE |
| err_o | output | 1 | One-cycle pulse after an illegal command |
| open_o | output | NUM_BANKS | Per-bank row open |
| prech_o | output | NUM_BANKS | Per-bank precharge in progress |
| idle_o | output | NUM_BANKS | Per-bank idle |

## Verification
A wrong row-active or precharge count shows first as a status flip that comes a cycle early or late. When an auto-precharge starts, the open flag drops one cycle off the max(burst end, tRAS) point. When a precharge ends, the idle flag rises off schedule. A command placed at the window edge then draws an error pulse where none belongs, or misses one, in the very next cycle. A lost burst-terminate target or a stale pending flag stays hidden until the next BURST TERMINATE or command to that bank. The bench therefore issues such probes directly after each stage.

// File: rtl/bank_apc_tracker.sv
module bank_apc_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 ap_i,
  output logic                 err_o,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [NUM_BANKS-1:0] prech_o,
  output logic [NUM_BANKS-1:0] idle_o
);
  localparam int HB   = BURST_LEN / 2;
  localparam int RASW = $clog2(T_RAS + 1);
  localparam int RPW  = $clog2(T_RP + 1);
  localparam int BCW  = $clog2(HB + 1);
  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_BST = 3'd5;

  logic [NUM_BANKS-1:0] open_v, ap_v, ras_done, burst_v;
  logic [BA_W-1:0]      lr_bank_q;
  logic                 lr_rd_q, lr_ap_q, err_q, bad;

  wire tgt_open  = open_v[bank_i];
  wire tgt_prech = prech_o[bank_i];
  wire tgt_ap    = ap_v[bank_i];

  always_comb begin
    bad = 1'b0;
    case (cmd_i)
      C_ACT:      bad = tgt_open | tgt_prech;
      C_RD, C_WR: bad = ~tgt_open | tgt_ap | tgt_prech;
      C_PRE:      bad = tgt_prech | tgt_ap | (tgt_open & ~ras_done[bank_i]);
      C_BST:      bad = ~lr_rd_q | lr_ap_q | ~burst_v[lr_bank_q];
      default:    bad = 1'b0;
    endcase
  end

  wire ok = ~bad;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic            open_q, ap_q;
    logic [RASW-1:0] ras_q;
    logic [RPW-1:0]  rp_q;
    logic [BCW-1:0]  bc_q;

    wire hit   = ok && (bank_i == BA_W'(g));
    wire ap_go = ap_q && (bc_q <= BCW'(1)) && (ras_q == '0);
    wire bst   = ok && (cmd_i == C_BST) && (lr_bank_q == BA_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        ap_q   <= 1'b0;
        ras_q  <= '0;
        rp_q   <= '0;
        bc_q   <= '0;
      end else begin
        if (ras_q != '0) ras_q <= ras_q - 1'b1;
        if (rp_q  != '0) rp_q  <= rp_q - 1'b1;
        if (bc_q  != '0) bc_q  <= bc_q - 1'b1;
        if (ap_go) begin
          open_q <= 1'b0;
          ap_q   <= 1'b0;
          rp_q   <= RPW'(T_RP - 1);
        end
        if (hit) begin
          case (cmd_i)
            C_ACT: begin
              open_q <= 1'b1;
              ras_q  <= RASW'(T_RAS - 1);
            end
            C_RD, C_WR: begin
              bc_q <= BCW'(HB);
              ap_q <= ap_i;
            end
            C_PRE: if (open_q) begin
              open_q <= 1'b0;
              bc_q   <= '0;
              rp_q   <= RPW'(T_RP - 1);
            end
            default: ;
          endcase
        end
        if (bst) bc_q <= '0;
      end
    end

    assign open_v[g]   = open_q;
    assign ap_v[g]     = ap_q;
    assign ras_done[g] = (ras_q == '0);
    assign burst_v[g]  = (bc_q != '0);
    assign prech_o[g]  = (rp_q != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_bank_q <= '0;
      lr_rd_q   <= 1'b0;
      lr_ap_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= bad;
      if (ok && (cmd_i == C_RD || cmd_i == C_WR)) begin
        lr_bank_q <= bank_i;
        lr_rd_q   <= (cmd_i == C_RD);
        lr_ap_q   <= ap_i;
      end
    end
  end

  assign err_o  = err_q;
  assign open_o = open_v;
  assign idle_o = ~(open_v | prech_o);
endmodule

module bank_apc_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_i,
  input logic [BA_W-1:0]      bank_i,
  input logic                 err_o,
  input logic [NUM_BANKS-1:0] open_o,
  input logic [NUM_BANKS-1:0] prech_o
);
  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1 && !open_o[bank_i] && !prech_o[bank_i]) |=> (open_o[$past(bank_i)] && !err_o));

  // R2
  act_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1 && open_o[bank_i]) |=> err_o);

  // R4
  prech_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i inside {3'd1, 3'd2, 3'd3, 3'd4} && prech_o[bank_i]) |=> err_o);

  // R5
  rw_closed_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i inside {3'd2, 3'd3} && !open_o[bank_i]) |=> err_o);

  // R10
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd0 || cmd_i > 3'd5) |=> !err_o);

  // R3
  open_prech_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o & prech_o) == '0);

  // R3
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd4 && !open_o[bank_i] && !prech_o[bank_i]) |=> !prech_o[$past(bank_i)]);
endmodule

bind bank_apc_tracker bank_apc_tracker_chk #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
  .err_o(err_o), .open_o(open_o), .prech_o(prech_o)
);

// File: tb/sim_bank_apc_tracker.sv
`timescale 1ns/1ps
module sim_bank_apc_tracker;
  localparam int NB = 4, BL = 4, TRAS = 6, TRP = 3, BAW = 2, HB = BL / 2;
  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, BST = 5;

  logic clk = 0, rst_n = 0, ap = 0, err;
  logic [2:0] cmd = NOP;
  logic [BAW-1:0] bank = '0;
  logic [NB-1:0] open_s, prech_s, idle_s;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bank_apc_tracker #(.NUM_BANKS(NB), .BURST_LEN(BL), .T_RAS(TRAS), .T_RP(TRP), .BA_W(BAW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
    .err_o(err), .open_o(open_s), .prech_o(prech_s), .idle_o(idle_s));

  bit m_open[NB], m_ap[NB];
  int m_ras[NB], m_rp[NB], m_bc[NB];
  int lr_b = 0;
  bit lr_rd = 0, lr_ap = 0, m_err = 0;

  function automatic bit model_bad(logic [2:0] c, int b);
    case (c)
      ACT:     return m_open[b] || m_rp[b] != 0;
      RD, WR:  return !m_open[b] || m_ap[b] || m_rp[b] != 0;
      PRE:     return m_rp[b] != 0 || m_ap[b] || (m_open[b] && m_ras[b] != 0);
      BST:     return !lr_rd || lr_ap || m_bc[lr_b] == 0;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(logic [2:0] c, int b, logic a);
    bit bad = model_bad(c, b);
    bit go[NB];
    for (int k = 0; k < NB; k++) go[k] = m_ap[k] && m_bc[k] <= 1 && m_ras[k] == 0;
    for (int k = 0; k < NB; k++) begin
      if (m_ras[k] > 0) m_ras[k]--;
      if (m_rp[k] > 0) m_rp[k]--;
      if (m_bc[k] > 0) m_bc[k]--;
      if (go[k]) begin m_open[k] = 0; m_ap[k] = 0; m_rp[k] = TRP - 1; end
    end
    if (!bad) begin
      case (c)
        ACT: begin m_open[b] = 1; m_ras[b] = TRAS - 1; end
        RD, WR: begin m_bc[b] = HB; m_ap[b] = a; lr_b = b; lr_rd = (c == RD); lr_ap = a; end
        PRE: if (m_open[b]) begin m_open[b] = 0; m_bc[b] = 0; m_rp[b] = TRP - 1; end
        BST: m_bc[lr_b] = 0;
        default: ;
      endcase
    end
    m_err = bad;
  endtask

  function automatic logic [3*NB:0] model_vec();
    logic [3*NB:0] v;
    v[3*NB] = m_err;
    for (int k = 0; k < NB; k++) begin
      v[k] = m_open[k];
      v[NB + k] = m_rp[k] != 0;
      v[2*NB + k] = !m_open[k] && m_rp[k] == 0;
    end
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [2:0] c, int b, logic a, string tag);
    cmd = c; bank = BAW'(b); ap = a;
    model_step(c, b, a);
    @(posedge clk); #1;
    check(tag, 32'({err, idle_s, prech_s, open_s}), 32'(model_vec()));
    @(negedge clk);
    cmd = NOP; ap = 0;
  endtask

  task automatic nops(int n, string tag);
    for (int i = 0; i < n; i++) cyc(NOP, 0, 0, tag);
  endtask

  initial begin
    for (int k = 0; k < NB; k++) begin
      m_open[k] = 0; m_ap[k] = 0; m_ras[k] = 0; m_rp[k] = 0; m_bc[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 idle", 32'(idle_s), 32'hF);
    check("R1 open", 32'({open_s, prech_s, err}), 0);

    // bank 0: ACT c0, RD+AP c1 -> start at max(3,6)=6
    cyc(ACT, 0, 0, "R2");           check("R2 open", 32'(open_s[0]), 1);
    cyc(RD, 0, 1, "R6");
    cyc(ACT, 1, 0, "R8 other bank"); check("R8 no err", 32'(err), 0);
    cyc(RD, 0, 0, "R8 pending");     check("R8 err", 32'(err), 1);
    nops(2, "R6");                   check("R6 still open", 32'(open_s[0]), 1);
    nops(1, "R6");                   check("R6 start", 32'({open_s[0], prech_s[0]}), 32'b01);
    cyc(ACT, 0, 0, "R4");            check("R4 err", 32'(err), 1);
    nops(1, "R6");                   check("R6 idle", 32'(idle_s[0]), 1);

    // bank 1 active since c2, RD+AP at c10 -> burst end dominates
    nops(1, "R6");
    cyc(RD, 1, 1, "R6");
    nops(1, "R6");                   check("R6 burst end open", 32'(open_s[1]), 1);
    nops(1, "R6");                   check("R6 burst end prech", 32'(prech_s[1]), 1);
    nops(2, "R6");                   check("R6 idle b1", 32'(idle_s[1]), 1);

    // R7 non-persistent flag
    cyc(ACT, 0, 0, "R7");
    cyc(RD, 0, 0, "R7");
    nops(10, "R7");                  check("R7 stays open", 32'(open_s[0]), 1);

    // R9 burst terminate
    cyc(RD, 0, 0, "R9");
    cyc(BST, 3, 0, "R9");            check("R9 accepted", 32'({err, open_s[0]}), 32'b01);
    cyc(BST, 0, 0, "R9");            check("R9 second", 32'(err), 1);
    cyc(WR, 0, 0, "R9");
    cyc(BST, 0, 0, "R9");            check("R9 after write", 32'(err), 1);
    cyc(RD, 0, 1, "R9");
    cyc(BST, 0, 0, "R9");            check("R9 ap read", 32'(err), 1);
    nops(4, "R9");

    // R3 explicit precharge window, R5
    cyc(RD, 3, 0, "R5");             check("R5 err", 32'(err), 1);
    cyc(ACT, 3, 0, "R3");
    cyc(PRE, 3, 0, "R3");            check("R3 early", 32'({err, open_s[3]}), 32'b11);
    nops(4, "R3");
    cyc(PRE, 3, 0, "R3");            check("R3 legal", 32'({err, prech_s[3]}), 32'b01);
    nops(1, "R3");                   check("R3 prech", 32'(prech_s[3]), 1);
    nops(1, "R3");                   check("R3 idle", 32'(idle_s[3]), 1);
    cyc(PRE, 3, 0, "R3");            check("R3 idle pre", 32'({err, idle_s[3]}), 32'b01);

    // R10 unused codes
    cyc(3'd6, 0, 1, "R10");          check("R10 code6", 32'(err), 0);
    cyc(3'd7, 1, 0, "R10");          check("R10 code7", 32'(err), 0);

    void'($urandom(32'h5eed));
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 12;
      logic [2:0] c = (r < 4) ? NOP : (r < 6) ? ACT : (r < 8) ? RD : (r == 8) ? WR :
                      (r < 10) ? PRE : (r == 10) ? BST : 3'(6 + ($urandom % 2));
      cyc(c, int'($urandom % NB), logic'($urandom % 2), "R2 R4 R6 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule